// File: doc/BRIEF.md
# NAND Flash Host Byte Interface

This block sits between a simple byte-wide host bus and a single raw 8-bit NAND flash device. The host sees a 2 KiB data window, a small register area and a status byte. Every access to the data window turns into exactly one data byte cycle on the flash bus. A write turns into a write-enable pulse, and a read into a read-enable pulse whose sampled byte goes back to the host. In the register area, even offsets alias one control register. That register drives chip enable (stored active-low), the command latch line and the address latch line. Odd offsets form a port that sends one byte to the flash.

Whether a port byte is taken as a command or as an address depends only on the latch bits last written to the control register. Writes to the flash are posted: the host gets its acknowledge one clock after the request is taken, and the controller-busy flag stays set until the byte cycle has fully finished. Software polls that flag before issuing the next byte. The status byte also reports the synchronized ready/busy pin of the flash and a sticky command-complete flag. That flag is set when the pin returns to ready and is cleared when the status byte is read.

The host holds `bus_req` with stable address and data until it sees a one-clock `bus_ack`, then drops it. Pin timing is fixed by parameters: one setup clock, two strobe clocks and one hold clock for writes, and two strobe clocks for reads.

Top module: `nand_host_if`

## Requirements
- R1: After reset the control register reads 0x01, so `nf_ce_n`=1, `nf_cle`=0 and `nf_ale`=0. `nf_we_n`=1, `nf_re_n`=1 and `nf_dq_oe`=0. With the ready/busy pin high, the status byte reads 0x08.
- R2: A write to any even offset from 0x800 to 0x80E loads bits 4:0 of the write data into the control register, and a read of any even offset returns it with bits 7:5 as zero. Bit 0 drives `nf_ce_n`, bit 1 drives `nf_cle` and bit 2 drives `nf_ale`. Bits 3 and 4 (interrupt enables) are only stored.
- R3: A write to any odd offset from 0x801 to 0x80F starts a flash write cycle. `nf_dq_oe` is high and `nf_dq_out` holds the byte for 4 clocks (1 setup, 2 strobe, 1 hold). `nf_we_n` is low for exactly the 2 middle clocks. `nf_cle` and `nf_ale` keep the control register value throughout.
- R4: A flash write is acknowledged on the clock after it is accepted. Status bit 2 (controller busy) is 1 from that clock until the hold clock has ended, and 0 after.
- R5: A write to any offset from 0x000 to 0x7FF performs the same flash write cycle as R3 with the written byte.
- R6: A read of any offset from 0x000 to 0x7FF drives `nf_re_n` low for exactly 2 clocks. It samples `nf_dq_in` at the end of the second clock and returns that byte with `bus_ack` on the next clock, 3 clocks after acceptance. `nf_we_n` and `nf_re_n` are never low together.
- R7: The status byte at offset 0x810 has bit 3 = flash ready, bit 2 = controller busy, bit 1 = command complete, bit 0 = 0, and bits 7:4 = 0.
- R8: Status bit 3 follows `nf_rb_n` through a two-stage synchronizer. A status read taken on the first clock after the pin changes still shows the old level.
- R9: Status bit 1 is set on a rising edge of the synchronized ready/busy pin and is cleared by a status read. When both happen on the same clock, set wins.
- R10: While a flash cycle is running, every access except one to the status or unused offsets is held unacknowledged until the cycle ends. So the latch and enable pins never change inside a cycle.
- R11: Writes to offset 0x810 and to unused offsets above it are acknowledged but change neither the control register nor the flash pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Host request, held until `bus_ack` |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid with `bus_ack` |
| bus_ack | output | 1 | One-clock completion pulse |
| nf_ce_n | output | 1 | Flash chip enable, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write enable strobe, active low |
| nf_re_n | output | 1 | Read enable strobe, active low |
| nf_dq_out | output | 8 | Data driven to the flash |
| nf_dq_oe | output | 1 | Output enable for `nf_dq_out` |
| nf_dq_in | input | 8 | Data from the flash |
| nf_rb_n | input | 1 | Flash ready (1) / busy (0) |

## Verification
A posted write is acknowledged one clock after it is taken, and a data read three clocks after. A control access issued right behind a port write waits five clocks, because the running cycle holds it. The bench drives requests half a cycle away from the clock edge and counts clocks from request to acknowledge against those figures. The strobe widths are counted on the pins, and each written byte is compared at the rising edge of `nf_we_n` against a queue filled by the driver. Status reads are placed relative to pin changes so that the two-clock synchronizer delay and the clear-on-read flag land on known values.

// File: rtl/nand_host_pkg.sv
package nand_host_pkg;

  typedef enum logic [2:0] {
    RG_DATA,
    RG_CTRL,
    RG_PORT,
    RG_STAT,
    RG_NONE
  } region_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD
  } phase_e;

  localparam int CTL_W    = 5;
  localparam int CTL_CE   = 0;
  localparam int CTL_CLE  = 1;
  localparam int CTL_ALE  = 2;

  localparam int STS_DONE = 1;
  localparam int STS_BUSY = 2;
  localparam int STS_RDY  = 3;

  localparam logic [CTL_W-1:0] CTL_RESET = 5'h01;

endpackage

// File: rtl/nand_bus_decode.sv
module nand_bus_decode
  import nand_host_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int WIN_BYTES  = 2048,
  parameter int ALIAS_SPAN = 16
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region
);

  localparam logic [ADDR_W-1:0] REG_LO = ADDR_W'(WIN_BYTES);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(WIN_BYTES + ALIAS_SPAN);

  always_comb begin
    if (addr < REG_LO) begin
      region = RG_DATA;
    end else if (addr < STAT_A) begin
      region = addr[0] ? RG_PORT : RG_CTRL;
    end else if (addr == STAT_A) begin
      region = RG_STAT;
    end else begin
      region = RG_NONE;
    end
  end

endmodule

// File: rtl/nand_rb_sync.sv
module nand_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rb_n,
  output logic rdy,
  output logic rise
);

  logic [STAGES:0] chain_q;
  logic [STAGES:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-1:0], rb_n};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rdy  = chain_q[STAGES-1];
  assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];

  // R9: an edge report lasts one clock only
  a_r9_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/nand_cycle_engine.sv
module nand_cycle_engine
  import nand_host_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int SETUP_CYC  = 1,
  parameter int STROBE_CYC = 2,
  parameter int HOLD_CYC   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_wr,
  input  logic              start_rd,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] dq_in,
  output logic              we_n,
  output logic              re_n,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              busy,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);

  localparam int MAX_A = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
  localparam int MAX_C = (MAX_A > HOLD_CYC) ? MAX_A : HOLD_CYC;
  localparam int CNT_W = (MAX_C < 2) ? 1 : $clog2(MAX_C);

  phase_e              phase_q, phase_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic                is_rd_q, is_rd_d;
  logic [DATA_W-1:0]   dq_q, dq_d;
  logic                oe_q, oe_d;
  logic                we_n_q, we_n_d;
  logic                re_n_q, re_n_d;
  logic                rdv_q, rdv_d;
  logic [DATA_W-1:0]   rdd_q, rdd_d;
  logic                last;

  assign last = (cnt_q == '0);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    is_rd_d = is_rd_q;
    dq_d    = dq_q;
    oe_d    = oe_q;
    rdv_d   = 1'b0;
    rdd_d   = rdd_q;
    case (phase_q)
      PH_IDLE: begin
        if (start_wr) begin
          phase_d = PH_SETUP;
          cnt_d   = CNT_W'(SETUP_CYC - 1);
          is_rd_d = 1'b0;
          dq_d    = wdata;
          oe_d    = 1'b1;
        end else if (start_rd) begin
          phase_d = PH_STROBE;
          cnt_d   = CNT_W'(STROBE_CYC - 1);
          is_rd_d = 1'b1;
        end
      end
      PH_SETUP: begin
        if (last) begin
          phase_d = PH_STROBE;
          cnt_d   = CNT_W'(STROBE_CYC - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_STROBE: begin
        if (last) begin
          if (is_rd_q) begin
            phase_d = PH_IDLE;
            rdv_d   = 1'b1;
            rdd_d   = dq_in;
          end else begin
            phase_d = PH_HOLD;
            cnt_d   = CNT_W'(HOLD_CYC - 1);
          end
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_HOLD: begin
        if (last) begin
          phase_d = PH_IDLE;
          oe_d    = 1'b0;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
    we_n_d = !((phase_d == PH_STROBE) && !is_rd_d);
    re_n_d = !((phase_d == PH_STROBE) && is_rd_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      is_rd_q <= 1'b0;
      dq_q    <= '0;
      oe_q    <= 1'b0;
      we_n_q  <= 1'b1;
      re_n_q  <= 1'b1;
      rdv_q   <= 1'b0;
      rdd_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      is_rd_q <= is_rd_d;
      dq_q    <= dq_d;
      oe_q    <= oe_d;
      we_n_q  <= we_n_d;
      re_n_q  <= re_n_d;
      rdv_q   <= rdv_d;
      if (rdv_d) begin
        rdd_q <= rdd_d;
      end
    end
  end

  assign we_n     = we_n_q;
  assign re_n     = re_n_q;
  assign dq_out   = dq_q;
  assign dq_oe    = oe_q;
  assign busy     = (phase_q != PH_IDLE);
  assign rd_valid = rdv_q;
  assign rd_data  = rdd_q;

  // strobe width counters used only by the checks below
  logic [7:0] we_low_cnt, re_low_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_low_cnt <= '0;
      re_low_cnt <= '0;
    end else begin
      we_low_cnt <= we_n_q ? 8'd0 : we_low_cnt + 8'd1;
      re_low_cnt <= re_n_q ? 8'd0 : re_low_cnt + 8'd1;
    end
  end

  // R3: write strobe width
  a_r3_we_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n_q) |-> (we_low_cnt == 8'(STROBE_CYC)));
  // R3: data driven whenever the write strobe is low
  a_r3_oe_under_we: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n_q |-> oe_q);
  // R4: busy covers the write strobe
  a_r4_busy_over_we: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n_q |-> busy);
  // R6: read strobe width
  a_r6_re_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(re_n_q) |-> (re_low_cnt == 8'(STROBE_CYC)));
  // R6: strobes exclusive
  a_r6_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    we_n_q || re_n_q);

endmodule

// File: rtl/nand_host_if.sv
module nand_host_if
  import nand_host_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 8,
  parameter int WIN_BYTES   = 2048,
  parameter int ALIAS_SPAN  = 16,
  parameter int SYNC_STAGES = 2,
  parameter int SETUP_CYC   = 1,
  parameter int STROBE_CYC  = 2,
  parameter int HOLD_CYC    = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ack,
  output logic              nf_ce_n,
  output logic              nf_cle,
  output logic              nf_ale,
  output logic              nf_we_n,
  output logic              nf_re_n,
  output logic [DATA_W-1:0] nf_dq_out,
  output logic              nf_dq_oe,
  input  logic [DATA_W-1:0] nf_dq_in,
  input  logic              nf_rb_n
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_i_n = rst_pipe_q[1];

  region_e            region;
  logic               eng_busy, eng_rdv;
  logic [DATA_W-1:0]  eng_rdd;
  logic               flash_rdy, rb_rise;

  logic               accept, free_acc, held_ok;
  logic               start_wr, start_rd, ctl_wr, ctl_rd, stat_rd, any_ack;

  logic [CTL_W-1:0]   ctl_q, ctl_d;
  logic               done_q, done_d;
  logic               ack_q;
  logic [DATA_W-1:0]  rdata_q, rdata_d;
  logic [DATA_W-1:0]  stat_byte;

  nand_bus_decode #(
    .ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES), .ALIAS_SPAN(ALIAS_SPAN)
  ) i_decode (
    .addr(bus_addr), .region(region)
  );

  nand_rb_sync #(.STAGES(SYNC_STAGES)) i_rb_sync (
    .clk(clk), .rst_n(rst_i_n), .rb_n(nf_rb_n), .rdy(flash_rdy), .rise(rb_rise)
  );

  nand_cycle_engine #(
    .DATA_W(DATA_W), .SETUP_CYC(SETUP_CYC),
    .STROBE_CYC(STROBE_CYC), .HOLD_CYC(HOLD_CYC)
  ) i_engine (
    .clk(clk), .rst_n(rst_i_n),
    .start_wr(start_wr), .start_rd(start_rd),
    .wdata(bus_wdata), .dq_in(nf_dq_in),
    .we_n(nf_we_n), .re_n(nf_re_n),
    .dq_out(nf_dq_out), .dq_oe(nf_dq_oe),
    .busy(eng_busy), .rd_valid(eng_rdv), .rd_data(eng_rdd)
  );

  // request qualification
  always_comb begin
    accept   = bus_req && !bus_ack;
    free_acc = accept && ((region == RG_STAT) || (region == RG_NONE));
    held_ok  = accept && !eng_busy;
    start_wr = held_ok && bus_we && ((region == RG_DATA) || (region == RG_PORT));
    start_rd = held_ok && !bus_we && (region == RG_DATA);
    ctl_wr   = held_ok && bus_we && (region == RG_CTRL);
    ctl_rd   = held_ok && !bus_we && (region == RG_CTRL);
    stat_rd  = free_acc && !bus_we && (region == RG_STAT);
    any_ack  = free_acc || start_wr || ctl_wr || ctl_rd ||
               (held_ok && !bus_we && (region == RG_PORT));
  end

  always_comb begin
    stat_byte           = '0;
    stat_byte[STS_RDY]  = flash_rdy;
    stat_byte[STS_BUSY] = eng_busy;
    stat_byte[STS_DONE] = done_q;
  end

  always_comb begin
    ctl_d   = ctl_wr ? bus_wdata[CTL_W-1:0] : ctl_q;
    done_d  = rb_rise ? 1'b1 : (stat_rd ? 1'b0 : done_q);
    rdata_d = '0;
    if (stat_rd) begin
      rdata_d = stat_byte;
    end else if (ctl_rd) begin
      rdata_d = DATA_W'(ctl_q);
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      ctl_q   <= CTL_RESET;
      done_q  <= 1'b0;
      ack_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ctl_q  <= ctl_d;
      done_q <= done_d;
      ack_q  <= any_ack;
      if (any_ack) begin
        rdata_q <= rdata_d;
      end
    end
  end

  assign bus_ack   = ack_q || eng_rdv;
  assign bus_rdata = eng_rdv ? eng_rdd : rdata_q;
  assign nf_ce_n   = ctl_q[CTL_CE];
  assign nf_cle    = ctl_q[CTL_CLE];
  assign nf_ale    = ctl_q[CTL_ALE];

  // R4: acknowledge is a single-clock pulse
  a_r4_ack_pulse: assert property (@(posedge clk) disable iff (!rst_i_n)
    bus_ack |=> !bus_ack);
  // R10: control pins frozen while a flash cycle runs
  a_r10_ctl_frozen: assert property (@(posedge clk) disable iff (!rst_i_n)
    eng_busy |=> $stable(ctl_q));
  // R9: pin edge sets the flag
  a_r9_done_set: assert property (@(posedge clk) disable iff (!rst_i_n)
    rb_rise |=> done_q);
  // R9: status read clears the flag when no edge coincides
  a_r9_done_clear: assert property (@(posedge clk) disable iff (!rst_i_n)
    (stat_rd && !rb_rise) |=> !done_q);
  // R11: unused offsets never start a flash cycle
  a_r11_no_cycle: assert property (@(posedge clk) disable iff (!rst_i_n)
    (accept && (region == RG_NONE) && !eng_busy) |=> !eng_busy);

endmodule

// File: tb/test_nand_host_if.sv
`timescale 1ns/1ps
module test_nand_host_if;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_req, bus_we;
  logic [11:0] bus_addr;
  logic [7:0]  bus_wdata, bus_rdata;
  logic        bus_ack;
  logic        nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe;
  logic [7:0]  nf_dq_out, nf_dq_in;
  logic        nf_rb_n;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  nand_host_if i_nand_host_if (
    .clk(clk), .rst_n(rst_n),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .nf_ce_n(nf_ce_n), .nf_cle(nf_cle), .nf_ale(nf_ale),
    .nf_we_n(nf_we_n), .nf_re_n(nf_re_n),
    .nf_dq_out(nf_dq_out), .nf_dq_oe(nf_dq_oe),
    .nf_dq_in(nf_dq_in), .nf_rb_n(nf_rb_n)
  );

  // scoreboard queues: {cle, ale, byte} for flash writes, bytes for host reads
  logic [9:0]  fl_q[$];
  logic [7:0]  rd_q[$];
  string       rd_tag[$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic we, input logic [11:0] a, input logic [7:0] d, output int n);
    #2;
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!bus_ack);
    #2;
    bus_req = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    int n;
    xfer(1'b1, a, d, n);
  endtask

  task automatic rd_exp(input logic [11:0] a, input logic [7:0] exp, input string tag);
    int n;
    rd_q.push_back(exp);
    rd_tag.push_back(tag);
    xfer(1'b0, a, 8'h00, n);
  endtask

  task automatic fl_exp(input logic cle, input logic ale, input logic [7:0] b);
    fl_q.push_back({cle, ale, b});
  endtask

  // monitor: sampled on the falling clock edge, inputs move 2 ns later
  logic we_prev = 1'b1, re_prev = 1'b1;
  int   we_low = 0, re_low = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!we_prev && nf_we_n) begin
        chk("R3 we_n low clocks", we_low, 2);
        if (fl_q.size() == 0) begin
          chk("R11 unexpected flash write", 1, 0);
        end else begin
          logic [9:0] e;
          e = fl_q.pop_front();
          chk("R3/R5 flash byte cle ale", {nf_dq_oe, nf_cle, nf_ale, nf_dq_out}, {1'b1, e});
        end
        we_low = 0;
      end
      if (!re_prev && nf_re_n) begin
        chk("R6 re_n low clocks", re_low, 2);
        re_low = 0;
      end
      if (!nf_we_n) we_low++;
      if (!nf_re_n) re_low++;
      if (bus_ack && !bus_we) begin
        if (rd_q.size() == 0) begin
          chk("R7 unexpected read ack", 1, 0);
        end else begin
          logic [7:0] e;
          string t;
          e = rd_q.pop_front();
          t = rd_tag.pop_front();
          chk(t, bus_rdata, e);
        end
      end
    end
    we_prev = nf_we_n;
    re_prev = nf_re_n;
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog act=expired exp=done");
    finish_run();
  end

  initial begin
    int n;
    rst_n = 1'b0; bus_req = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    nf_dq_in = 8'hA5; nf_rb_n = 1'b1;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(5);

    // R1 reset state at pins and in registers
    chk("R1 pins", {nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe}, 6'b100110);
    rd_exp(12'h800, 8'h01, "R1 control reset");
    rd_exp(12'h810, 8'h08, "R1 R7 status reset");

    // R2 even alias, masking, pin mapping
    wr(12'h80A, 8'hFE);
    rd_exp(12'h804, 8'h1E, "R2 control alias");
    chk("R2 pins", {nf_ce_n, nf_cle, nf_ale}, 3'b011);

    // R3 command byte with CLE, then busy in status (R4)
    wr(12'h802, 8'h02);
    wait_cyc(2);
    fl_exp(1'b1, 1'b0, 8'h90);
    xfer(1'b1, 12'h801, 8'h90, n);
    chk("R4 posted write ack clocks", n, 1);
    rd_exp(12'h810, 8'h0C, "R4 busy during cycle");
    wait_cyc(6);
    rd_exp(12'h810, 8'h08, "R4 busy cleared");

    // R3 address byte with ALE on another odd alias
    wr(12'h80C, 8'h04);
    fl_exp(1'b0, 1'b1, 8'h2D);
    wr(12'h80F, 8'h2D);
    wait_cyc(6);

    // R5 data window writes at both ends
    wr(12'h800, 8'h00);
    fl_exp(1'b0, 1'b0, 8'h3C);
    wr(12'h7FF, 8'h3C);
    wait_cyc(6);
    fl_exp(1'b0, 1'b0, 8'h11);
    wr(12'h000, 8'h11);
    wait_cyc(6);

    // R6 data read with latency
    nf_dq_in = 8'h5A;
    rd_q.push_back(8'h5A);
    rd_tag.push_back("R6 read data");
    xfer(1'b0, 12'h123, 8'h00, n);
    chk("R6 read ack clocks", n, 3);
    wait_cyc(2);

    // R10 control write held behind a running cycle
    fl_exp(1'b0, 1'b0, 8'h77);
    wr(12'h801, 8'h77);
    xfer(1'b1, 12'h802, 8'h02, n);
    chk("R10 held control write clocks", n, 5);
    chk("R10 cle after cycle", nf_cle, 1'b1);
    wait_cyc(2);

    // R11 ignored writes
    wr(12'h810, 8'hFF);
    wr(12'h900, 8'h55);
    wait_cyc(8);
    rd_exp(12'h800, 8'h02, "R11 control unchanged");
    chk("R11 no flash cycle", fl_q.size(), 0);

    // R8 synchronizer latency, R9 sticky flag
    @(negedge clk);
    nf_rb_n = 1'b0;
    rd_exp(12'h810, 8'h08, "R8 old level after one clock");
    rd_exp(12'h810, 8'h00, "R8 busy seen");
    nf_rb_n = 1'b1;
    wait_cyc(4);
    rd_exp(12'h810, 8'h0A, "R9 complete set");
    rd_exp(12'h810, 8'h08, "R9 complete cleared");

    wait_cyc(4);
    chk("R3 queue drained", fl_q.size(), 0);
    chk("R7 read queue drained", rd_q.size(), 0);
    finish_run();
  end

endmodule